// File: doc/BRIEF.md
# Power-On Reset Sequencer

This block produces the internal reset for a small 8-bit controller core. A power-detect pulse presets a 12-bit idle down-counter to all ones. The counter counts down once per instruction cycle, which is the input clock divided by ten. While the power-on option is enabled, the core reset stays asserted until that counter underflows, which stretches reset over 4096 instruction cycles. After the underflow no further reset comes from the counter until a new power-detect pulse arrives. An external active-low reset pin also resets the core. The pin passes through a two-flop synchronizer, and only a low level that lasts one whole instruction cycle is accepted.

The block also hands the core its reset constants: the stack pointer start value (chosen from the RAM size parameter), the program counter start value, the preset for the dedicated output port, the high-impedance setup for the bidirectional ports and the widest watchdog service window. It holds the watchdog inhibited while reset is active. A clock-monitor flag stays low after power-up and rises only once the clock-good indication has been present for a fixed number of instruction cycles, between 16 and 32.

Top module: `rst_sequencer`

## Requirements
- R1: An instruction-cycle tick occurs once every DIV (default 10) input clocks, counted from the first clock after `pod_n` is released.
- R2: With `por_en` high, `core_rst_n` rises exactly 40961 clocks after the first clock edge at which `pod_n` is sampled high. That is 4096 ticks to underflow the counter preset to 0xFFF, plus one register stage.
- R3: With `por_en` high, `core_rst_n` is low at every point of the stretch window before the underflow.
- R4: After the underflow, `core_rst_n` stays high while `pod_n` stays high and the external pin is not held low.
- R5: A low level on `ext_rst_n` that lasts fewer than DIV clocks has no effect on `core_rst_n`. A low level of DIV+2 clocks or more drives `core_rst_n` low. `core_rst_n` returns high within 4 clocks after the pin goes high.
- R6: When the external reset is valid at the same time as the counter underflows, `core_rst_n` stays low until the pin is released.
- R7: With `por_en` low, `core_rst_n` goes high on the first clock after `pod_n` is released.
- R8: `clkmon_ok` is low while `pod_n` is low. It rises between 16 and 32 ticks after `clk_good` goes high. It is low on the clock after `clk_good` is sampled low.
- R9: The reset constants are as follows. `sp_rst` is 0x2F for RAM_BYTES=64 and 0x6F for RAM_BYTES=128. `pc_rst` is 0. `dport_rst` is all ones. `bio_cfg_rst` and `bio_dat_rst` are all zeros, which is the high-impedance input setup.
- R10: `wd_win_rst` is all ones. `wd_inhibit` is high exactly when `core_rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| pod_n | input | 1 | Power-detect pulse, active low, synchronous; also resets the block |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous to clk |
| por_en | input | 1 | Enables the reset stretch from the idle counter |
| clk_good | input | 1 | Clock-good indication |
| core_rst_n | output | 1 | Internal core reset, active low |
| sp_rst | output | 8 | Stack pointer reset value |
| pc_rst | output | 15 | Program counter reset value |
| dport_rst | output | 8 | Dedicated output port reset value |
| bio_cfg_rst | output | 8 | Bidirectional port direction reset value |
| bio_dat_rst | output | 8 | Bidirectional port data reset value |
| wd_win_rst | output | 2 | Watchdog service window reset value |
| wd_inhibit | output | 1 | Holds the watchdog off while reset is active |
| clkmon_ok | output | 1 | Clock-monitor flag; low means error |

## Verification
The two functions that can coincide are the idle counter underflowing and the external pin filter accepting a reset. Both feed the same core reset register. To provoke the collision, the bench gives a fresh power-detect pulse and holds the external pin low for the whole stretch window and beyond the underflow. It then judges that the core reset does not rise at the underflow but only a few clocks after the pin is released. It also measures the plain underflow release to the exact clock, and times the filter and clock-monitor windows against their lower and upper bounds.

// File: rtl/rst_seq_pkg.sv
// Package: shared constants and helpers for the reset sequencer.
// Assumes RAM sizes of 64 or 128 bytes; any other value maps to the 64-byte start value.
package rst_seq_pkg;

    localparam int PC_W   = 15;
    localparam int PORT_W = 8;
    localparam int SP_W   = 8;

    // Stack pointer start value for a given RAM size.
    function automatic logic [SP_W-1:0] sp_start(input int ram_bytes);
        return (ram_bytes == 128) ? 8'h6F : 8'h2F;
    endfunction

endpackage

// File: rtl/rst_cyc_tick.sv
// Instruction-cycle tick generator: one tick every DIV input clocks.
// Assumes DIV >= 2; the counter restarts at zero while rst_n is low.
module rst_cyc_tick #(
    parameter int DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] div_cnt;

    // Free-running modulo-DIV counter.
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_cnt <= '0;
        else if (div_cnt == LAST)
            div_cnt <= '0;
        else
            div_cnt <= div_cnt + 1'b1;
    end

    assign tick = rst_n && (div_cnt == LAST);

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R1

endmodule

// File: rtl/rst_pin_filter.sv
// External reset pin conditioner: a two-flop synchronizer followed by a width check.
// Assumes the pin is asynchronous to clk. A low level is accepted once it has been
// seen for DIV synchronized clocks, and it stays accepted until the pin goes high.
module rst_pin_filter #(
    parameter int DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic valid
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic sync1_q, sync2_q;
    logic [CW-1:0] low_cnt;

    // Bring the pin into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= 1'b1;
            sync2_q <= 1'b1;
        end else begin
            sync1_q <= pin_n;
            sync2_q <= sync1_q;
        end
    end

    // Count consecutive low samples and flag a valid reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
            valid   <= 1'b0;
        end else if (sync2_q) begin
            low_cnt <= '0;
            valid   <= 1'b0;
        end else if (low_cnt != LAST) begin
            low_cnt <= low_cnt + 1'b1;
        end else begin
            valid   <= 1'b1;
        end
    end

    AST_PIN_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid) |-> (low_cnt == LAST)); // R5

    AST_PIN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (sync2_q && valid) |=> !valid); // R5

endmodule

// File: rtl/rst_stretch_tmr.sv
// Idle down-counter for the reset stretch. A power-detect pulse presets it to all
// ones and arms it. It counts down once per tick and disarms on underflow; only a
// new power-detect pulse arms it again.
module rst_stretch_tmr #(
    parameter int TMR_W = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic active
);
    logic [TMR_W-1:0] tmr_cnt;

    // Preset, count down on ticks, disarm on underflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_cnt <= '1;
            active  <= 1'b1;
        end else if (active && tick) begin
            if (tmr_cnt == '0)
                active <= 1'b0;
            else
                tmr_cnt <= tmr_cnt - 1'b1;
        end
    end

    AST_TMR_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !active); // R4

    AST_TMR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(tmr_cnt) && $stable(active))); // R2

    AST_TMR_UNDERFLOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> ($past(tmr_cnt) == '0)); // R2

endmodule

// File: rtl/rst_clk_mon.sv
// Clock-monitor flag. It stays low after power-up and whenever clk_good is low.
// It rises once clk_good has been high for MON_CYC ticks. Assumes MON_CYC is
// between 16 and 32.
module rst_clk_mon #(
    parameter int MON_CYC = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic clk_good,
    output logic ok
);
    localparam int MW      = $clog2(MON_CYC + 1);
    localparam int MIN_CYC = 16;

    logic [MW-1:0] mon_cnt;

    // Count ticks of good clock; restart when the clock is lost.
    always_ff @(posedge clk) begin
        if (!rst_n || !clk_good) begin
            mon_cnt <= '0;
            ok      <= 1'b0;
        end else if (tick && !ok) begin
            if (mon_cnt == MW'(MON_CYC - 1))
                ok <= 1'b1;
            else
                mon_cnt <= mon_cnt + 1'b1;
        end
    end

    AST_MON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_good |=> !ok); // R8

    AST_MON_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ok) |-> (mon_cnt >= MW'(MIN_CYC - 1))); // R8

endmodule

// File: rtl/rst_sequencer.sv
// Reset sequencer top. It combines the idle-counter stretch (when enabled) and the
// filtered external pin into one registered core reset. It drives the reset
// constants for the core and the watchdog inhibit, and hosts the clock monitor.
// Assumes pod_n is a synchronous active-low pulse that also resets this block.
module rst_sequencer
    import rst_seq_pkg::*;
#(
    parameter int DIV       = 10,
    parameter int TMR_W     = 12,
    parameter int MON_CYC   = 24,
    parameter int RAM_BYTES = 64,
    parameter int WD_W      = 2
) (
    input  logic              clk,
    input  logic              pod_n,
    input  logic              ext_rst_n,
    input  logic              por_en,
    input  logic              clk_good,
    output logic              core_rst_n,
    output logic [SP_W-1:0]   sp_rst,
    output logic [PC_W-1:0]   pc_rst,
    output logic [PORT_W-1:0] dport_rst,
    output logic [PORT_W-1:0] bio_cfg_rst,
    output logic [PORT_W-1:0] bio_dat_rst,
    output logic [WD_W-1:0]   wd_win_rst,
    output logic              wd_inhibit,
    output logic              clkmon_ok
);
    logic tick;
    logic ext_valid;
    logic stretch_act;
    logic core_q;

    rst_cyc_tick #(.DIV(DIV)) u_tick (
        .clk   (clk),
        .rst_n (pod_n),
        .tick  (tick)
    );

    rst_pin_filter #(.DIV(DIV)) u_pin (
        .clk   (clk),
        .rst_n (pod_n),
        .pin_n (ext_rst_n),
        .valid (ext_valid)
    );

    rst_stretch_tmr #(.TMR_W(TMR_W)) u_tmr (
        .clk    (clk),
        .rst_n  (pod_n),
        .tick   (tick),
        .active (stretch_act)
    );

    rst_clk_mon #(.MON_CYC(MON_CYC)) u_mon (
        .clk      (clk),
        .rst_n    (pod_n),
        .tick     (tick),
        .clk_good (clk_good),
        .ok       (clkmon_ok)
    );

    // Register the combined reset request so the core sees a glitch-free reset.
    always_ff @(posedge clk) begin
        if (!pod_n)
            core_q <= 1'b0;
        else
            core_q <= !(ext_valid || (por_en && stretch_act));
    end

    assign core_rst_n  = core_q;
    assign wd_inhibit  = !core_q;
    assign sp_rst      = sp_start(RAM_BYTES);
    assign pc_rst      = '0;
    assign dport_rst   = '1;
    assign bio_cfg_rst = '0;
    assign bio_dat_rst = '0;
    assign wd_win_rst  = '1;

    AST_CORE_HOLD: assert property (@(posedge clk) disable iff (!pod_n)
        (por_en && stretch_act) |=> !core_rst_n); // R3

    AST_EXT_FORCE: assert property (@(posedge clk) disable iff (!pod_n)
        ext_valid |=> !core_rst_n); // R6

    AST_CORE_FREE: assert property (@(posedge clk) disable iff (!pod_n)
        (!ext_valid && !(por_en && stretch_act)) |=> core_rst_n); // R7

endmodule

// File: tb/rst_sequencer_tb.sv
`timescale 1ns/1ps
module rst_sequencer_tb;

    logic clk = 1'b0;
    logic pod_n = 1'b0;
    logic ext_rst_n = 1'b1;
    logic por_en = 1'b1;
    logic clk_good = 1'b0;

    logic        core_rst_n, wd_inhibit, clkmon_ok;
    logic [7:0]  sp_rst, dport_rst, bio_cfg_rst, bio_dat_rst;
    logic [14:0] pc_rst;
    logic [1:0]  wd_win_rst;

    logic        core2_rst_n, wd2_inhibit, mon2_ok;
    logic [7:0]  sp2_rst, dp2_rst, cfg2_rst, dat2_rst;
    logic [14:0] pc2_rst;
    logic [1:0]  win2_rst;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rst_sequencer u_dut (
        .clk(clk), .pod_n(pod_n), .ext_rst_n(ext_rst_n), .por_en(por_en),
        .clk_good(clk_good), .core_rst_n(core_rst_n), .sp_rst(sp_rst),
        .pc_rst(pc_rst), .dport_rst(dport_rst), .bio_cfg_rst(bio_cfg_rst),
        .bio_dat_rst(bio_dat_rst), .wd_win_rst(wd_win_rst),
        .wd_inhibit(wd_inhibit), .clkmon_ok(clkmon_ok)
    );

    rst_sequencer #(.RAM_BYTES(128)) u_dut128 (
        .clk(clk), .pod_n(pod_n), .ext_rst_n(ext_rst_n), .por_en(por_en),
        .clk_good(clk_good), .core_rst_n(core2_rst_n), .sp_rst(sp2_rst),
        .pc_rst(pc2_rst), .dport_rst(dp2_rst), .bio_cfg_rst(cfg2_rst),
        .bio_dat_rst(dat2_rst), .wd_win_rst(win2_rst),
        .wd_inhibit(wd2_inhibit), .clkmon_ok(mon2_ok)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clocks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Pulse pod_n low for a few clocks and release it on a falling edge.
    task automatic pod_pulse();
        @(negedge clk);
        pod_n = 1'b0;
        clocks(4);
        pod_n = 1'b1;
    endtask

    task automatic t_reset_state();
        clocks(3);
        check("R10 core reset low in pod", core_rst_n, 0);
        check("R10 wd_inhibit in reset", wd_inhibit, 1);
        check("R10 wd window max", wd_win_rst, 3);
        check("R8 clkmon low in pod", clkmon_ok, 0);
        check("R9 sp 64B", sp_rst, 'h2F);
        check("R9 sp 128B", sp2_rst, 'h6F);
        check("R9 pc zero", pc_rst, 0);
        check("R9 dport ones", dport_rst, 'hFF);
        check("R9 bio cfg zero", bio_cfg_rst, 0);
        check("R9 bio data zero", bio_dat_rst, 0);
    endtask

    // R1 R2 R3: exact release clock of the stretch.
    task automatic t_por_stretch();
        int n = 0;
        pod_n = 1'b1;
        while (n < 50000) begin
            @(posedge clk);
            @(negedge clk);
            n++;
            if (n == 20000) check("R3 held mid stretch", core_rst_n, 0);
            if (n == 40960) check("R3 held at underflow tick", core_rst_n, 0);
            if (core_rst_n) break;
        end
        check("R1 R2 release clock", n, 40961);
        check("R10 wd_inhibit released", wd_inhibit, 0);
    endtask

    // R4: no reset after underflow.
    task automatic t_no_rearm();
        int lows = 0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (!core_rst_n) lows++;
        end
        check("R4 no reset after underflow", lows, 0);
    endtask

    task automatic t_clk_mon();
        clk_good = 1'b1;
        clocks(150);
        check("R8 clkmon low before 16 ticks", clkmon_ok, 0);
        clocks(180);
        check("R8 clkmon high by 32 ticks", clkmon_ok, 1);
        clk_good = 1'b0;
        clocks(2);
        check("R8 clkmon drops on lost clock", clkmon_ok, 0);
        clk_good = 1'b1;
    endtask

    task automatic t_ext_pulse();
        int lows = 0;
        ext_rst_n = 1'b0;
        clocks(9);
        ext_rst_n = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!core_rst_n) lows++;
        end
        check("R5 short pulse ignored", lows, 0);
        ext_rst_n = 1'b0;
        clocks(20);
        check("R5 long pulse accepted", core_rst_n, 0);
        check("R10 wd_inhibit on ext reset", wd_inhibit, 1);
        ext_rst_n = 1'b1;
        clocks(5);
        check("R5 release after pin high", core_rst_n, 1);
    endtask

    task automatic t_por_off();
        por_en = 1'b0;
        pod_pulse();
        clocks(2);
        check("R7 no stretch when disabled", core_rst_n, 1);
        clocks(100);
        check("R7 still released", core_rst_n, 1);
        por_en = 1'b1;
    endtask

    // R6: pin held low across the underflow.
    task automatic t_ext_over_underflow();
        @(negedge clk);
        pod_n = 1'b0;
        ext_rst_n = 1'b0;
        clocks(4);
        pod_n = 1'b1;
        clocks(41400);
        check("R6 held past underflow by pin", core_rst_n, 0);
        ext_rst_n = 1'b1;
        clocks(2);
        check("R6 still low right after pin release", core_rst_n, 0);
        clocks(3);
        check("R6 released after pin", core_rst_n, 1);
    endtask

    initial begin
        t_reset_state();
        t_por_stretch();
        t_no_rearm();
        t_clk_mon();
        t_ext_pulse();
        t_por_off();
        t_ext_over_underflow();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        end
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        end
        $finish;
    end

endmodule